// File: doc/BRIEF.md
# Sampled Fault Input Detector

This block watches one active-low fault pin that arrives from outside the chip with no timing relation to the system clock. When the block recognises that the fault is present, it sets a detect flag and holds it set. While that flag is set, the block asks the output stage to release the protected pins to high impedance. If the interrupt enable is on, it also raises an interrupt request.

A two-bit mode field picks how the fault is recognised. In the first mode, any falling edge on the pin counts as a fault. The other three modes are meant for noisy pins. They sample the pin on a slow tick taken from a built-in free-running prescaler, and they report a fault only after sixteen low samples in a row. Each of these modes uses a different tick rate.

Software clears the flag with a one-cycle strobe. A strobe that arrives while the fault is still being recognised has no effect.

Top module: `fault_sense`

## Requirements
- R1: While reset is low, and after reset is released, `detect_flag`, `hiz_req` and `irq_req` are all low. Asserting reset clears a set flag at once, without waiting for a clock edge.
- R2: With `mode` = 2'b00, a high-to-low transition on `fault_n` sets the flag. This holds even for a low pulse of one clock, and the flag is visible within three clocks. A pin that stays low does not set the flag again once it has been cleared.
- R3: With `mode` = 2'b01, the pin is sampled once every 8 clocks. The flag is set only after 16 consecutive low samples: never within 120 clocks of low, and always within 132.
- R4: With `mode` = 2'b10, the pin is sampled once every 16 clocks and needs 16 consecutive low samples: never within 240 clocks, and always within 260.
- R5: With `mode` = 2'b11, the pin is sampled once every 128 clocks and needs 16 consecutive low samples: never within 1920 clocks, and always within 2052.
- R6: In a sampled mode, any high sample sets the run of low samples back to zero. Two low stretches that are each too short do not add up, even when their total would be long enough.
- R7: Once set, the flag stays set until `flag_clr` is pulsed. A pulse given while a sampled-mode fault is still recognised (pin still low) is ignored.
- R8: `hiz_req` is high exactly when the flag is set.
- R9: `irq_req` is high only when the flag is set and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fault_n | input | 1 | Raw asynchronous fault pin, low = fault |
| mode | input | 2 | Recognition method: 00 edge, 01 every 8, 10 every 16, 11 every 128 clocks |
| flag_clr | input | 1 | One-cycle strobe that clears the detect flag |
| irq_en | input | 1 | Interrupt enable |
| detect_flag | output | 1 | Latched fault-detected flag |
| hiz_req | output | 1 | Request to put the protected outputs into high impedance |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions assume that `mode` changes only while the pin has been high for longer than one period of the slowest tick. With that assumption, no partial low run and no stale edge state carries across a mode change. The bench sets each mode only after the pin has been held high for 140 clocks and the flag has been cleared. It also drives the pin and the strobes on the falling clock edge, so the synchroniser always captures a clean level. The thresholds checked in R3 to R5 already include the two-clock synchroniser delay and the unknown phase of the prescaler, so the checks hold for any prescaler phase.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic [1:0] {
    DET_EDGE   = 2'b00,
    DET_SLOW_A = 2'b01,
    DET_SLOW_B = 2'b10,
    DET_SLOW_C = 2'b11
  } det_mode_e;

  localparam int NUM_RATES = 3;
endpackage

// File: rtl/fsd_rst_sync.sv
module fsd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fsd_pin_sync.sv
module fsd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign pin_sync = sh_q[STAGES-1];
endmodule

// File: rtl/fsd_rate_gen.sv
module fsd_rate_gen #(
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic                           clk,
  input  logic                           rst_n,
  output logic [fsd_pkg::NUM_RATES-1:0]  tick
);
  localparam int PRE_W = $clog2(DIV_C);
  localparam int DIVS [fsd_pkg::NUM_RATES] = '{DIV_A, DIV_B, DIV_C};

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < fsd_pkg::NUM_RATES; g++) begin : g_tick
    localparam int LW = $clog2(DIVS[g]);
    assign tick[g] = &cnt_q[LW-1:0];
  end
endmodule

// File: rtl/fsd_recog.sv
module fsd_recog #(
  parameter int LOW_RUN = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  fsd_pkg::det_mode_e            mode,
  input  logic [fsd_pkg::NUM_RATES-1:0] tick,
  input  logic                          pin_sync,
  output logic                          hit
);
  import fsd_pkg::*;

  localparam int RUN_W = $clog2(LOW_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOW_RUN);

  logic             prev_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_d;
  logic             run_en;
  logic             sel_tick;

  always_comb begin
    unique case (mode)
      DET_SLOW_A: sel_tick = tick[0];
      DET_SLOW_B: sel_tick = tick[1];
      DET_SLOW_C: sel_tick = tick[2];
      default:    sel_tick = 1'b0;
    endcase
  end

  always_comb begin
    run_en = (mode == DET_EDGE) || sel_tick;
    run_d  = run_q;
    if (mode == DET_EDGE) begin
      run_d = '0;
    end else if (pin_sync) begin
      run_d = '0;
    end else if (run_q != RUN_FULL) begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      prev_q <= 1'b1;
    end else begin
      prev_q <= pin_sync;
      if (run_en) run_q <= run_d;
    end
  end

  assign hit = (mode == DET_EDGE) ? (prev_q & ~pin_sync) : (run_q == RUN_FULL);
endmodule

// File: rtl/fault_sense.sv
module fault_sense #(
  parameter int DIV_A   = 8,
  parameter int DIV_B   = 16,
  parameter int DIV_C   = 128,
  parameter int LOW_RUN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_n,
  input  logic [1:0] mode,
  input  logic       flag_clr,
  input  logic       irq_en,
  output logic       detect_flag,
  output logic       hiz_req,
  output logic       irq_req
);
  import fsd_pkg::*;

  logic                 rst_i_n;
  logic                 pin_sync;
  logic [NUM_RATES-1:0] tick;
  logic                 hit;
  logic                 flag_q;
  logic                 flag_d;
  det_mode_e            mode_e;

  assign mode_e = det_mode_e'(mode);

  fsd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  fsd_pin_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .pin_raw  (fault_n),
    .pin_sync (pin_sync)
  );

  fsd_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
    .clk   (clk),
    .rst_n (rst_i_n),
    .tick  (tick)
  );

  fsd_recog #(.LOW_RUN(LOW_RUN)) u_recog (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .mode     (mode_e),
    .tick     (tick),
    .pin_sync (pin_sync),
    .hit      (hit)
  );

  always_comb begin
    flag_d = flag_q;
    if (hit)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) flag_q <= 1'b0;
    else          flag_q <= flag_d;
  end

  assign detect_flag = flag_q;
  assign hiz_req     = flag_q;
  assign irq_req     = flag_q & irq_en;
endmodule

// File: rtl/fault_sense_chk.sv
module fault_sense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       flag_clr,
  input logic       irq_en,
  input logic       pin_sync,
  input logic       detect_flag,
  input logic       hiz_req,
  input logic       irq_req
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!detect_flag && !hiz_req && !irq_req);
    end
  end

  // R2
  edge_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) && $rose(detect_flag) |-> !$past(pin_sync) && $past(pin_sync, 2));

  // R3 R4 R5
  level_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) && $rose(detect_flag) |-> !$past(pin_sync));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_flag && !flag_clr |=> detect_flag);

  // R8
  hiz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req && !flag_clr |=> hiz_req);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_req);
endmodule

bind fault_sense fault_sense_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .flag_clr    (flag_clr),
  .irq_en      (irq_en),
  .pin_sync    (pin_sync),
  .detect_flag (detect_flag),
  .hiz_req     (hiz_req),
  .irq_req     (irq_req)
);

// File: tb/fault_sense_tb_top.sv
`timescale 1ns/1ps
module fault_sense_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fault_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       flag_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       detect_flag;
  logic       hiz_req;
  logic       irq_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  fault_sense dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_n     (fault_n),
    .mode        (mode),
    .flag_clr    (flag_clr),
    .irq_en      (irq_en),
    .detect_flag (detect_flag),
    .hiz_req     (hiz_req),
    .irq_req     (irq_req)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [11:0] low1;
    logic [11:0] gap;
    logic [11:0] low2;
    logic        exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 12'd0,   12'd0,  12'd4,    1'b1},
    '{2'b01, 12'd0,   12'd0,  12'd120,  1'b0},
    '{2'b01, 12'd0,   12'd0,  12'd132,  1'b1},
    '{2'b10, 12'd0,   12'd0,  12'd240,  1'b0},
    '{2'b10, 12'd0,   12'd0,  12'd260,  1'b1},
    '{2'b11, 12'd0,   12'd0,  12'd1920, 1'b0},
    '{2'b11, 12'd0,   12'd0,  12'd2052, 1'b1},
    '{2'b01, 12'd100, 12'd10, 12'd120,  1'b0},
    '{2'b10, 12'd200, 12'd18, 12'd240,  1'b0},
    '{2'b01, 12'd100, 12'd10, 12'd132,  1'b1}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    wait_cyc(1);
    flag_clr = 1'b0;
    wait_cyc(1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic string vec_tag(input vec_t v);
    if (v.gap != 0) return "R6";
    case (v.md)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(10 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R1: reset state, during and after reset
    wait_cyc(3);
    check(detect_flag, 1'b0, "R1 flag in reset");
    rst_n = 1'b1;
    wait_cyc(5);
    check(detect_flag, 1'b0, "R1 flag after reset");
    check(hiz_req, 1'b0, "R1 hiz after reset");
    check(irq_req, 1'b0, "R1 irq after reset");

    irq_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      mode = VECS[i].md;
      fault_n = 1'b1;
      wait_cyc(4);
      if (VECS[i].low1 != 0) begin
        fault_n = 1'b0;
        wait_cyc(int'(VECS[i].low1));
        fault_n = 1'b1;
        wait_cyc(int'(VECS[i].gap));
      end
      fault_n = 1'b0;
      wait_cyc(int'(VECS[i].low2));
      check(detect_flag, VECS[i].exp, $sformatf("%s vector %0d flag", vec_tag(VECS[i]), i));
      check(hiz_req, VECS[i].exp, $sformatf("R8 vector %0d hiz", i));
      check(irq_req, VECS[i].exp, $sformatf("R9 vector %0d irq", i));
      fault_n = 1'b1;
      wait_cyc(140);
      pulse_clr();
    end

    // R2: one-cycle low pulse in edge mode
    mode = 2'b00;
    wait_cyc(4);
    fault_n = 1'b0;
    wait_cyc(1);
    fault_n = 1'b1;
    wait_cyc(3);
    check(detect_flag, 1'b1, "R2 one-cycle pulse");
    pulse_clr();

    // R2: held low in edge mode, clear works and flag is not set again
    fault_n = 1'b0;
    wait_cyc(5);
    check(detect_flag, 1'b1, "R2 held low first edge");
    pulse_clr();
    wait_cyc(10);
    check(detect_flag, 1'b0, "R2 no re-trigger while low");
    fault_n = 1'b1;
    wait_cyc(140);

    // R7: clear ignored while a sampled fault persists
    mode = 2'b01;
    wait_cyc(4);
    fault_n = 1'b0;
    wait_cyc(140);
    check(detect_flag, 1'b1, "R3 held low detect");
    pulse_clr();
    check(detect_flag, 1'b1, "R7 clear ignored while low");

    // R9 / R8: interrupt gating with flag set
    irq_en = 1'b0;
    wait_cyc(1);
    check(irq_req, 1'b0, "R9 irq masked");
    check(hiz_req, 1'b1, "R8 hiz with flag");
    irq_en = 1'b1;
    wait_cyc(1);
    check(irq_req, 1'b1, "R9 irq enabled");

    // R7: flag sticky after the fault goes away
    fault_n = 1'b1;
    wait_cyc(200);
    check(detect_flag, 1'b1, "R7 sticky without clear");
    pulse_clr();
    check(detect_flag, 1'b0, "R7 clear after release");
    check(hiz_req, 1'b0, "R8 hiz cleared");

    // R1: asynchronous reset clears a set flag
    mode = 2'b00;
    wait_cyc(4);
    fault_n = 1'b0;
    wait_cyc(4);
    check(detect_flag, 1'b1, "R2 set before reset");
    #1 rst_n = 1'b0;
    #1 check(detect_flag, 1'b0, "R1 async clear");
    wait_cyc(2);
    fault_n = 1'b1;
    rst_n = 1'b1;
    wait_cyc(5);
    check(detect_flag, 1'b0, "R1 after second reset");

    report();
  end
endmodule